// File: doc/BRIEF.md
# Colored Button Code Lock

This block is a clocked Moore state machine that releases a door lock after a fixed button code is entered. The user first presses a start button. The user then presses three colored buttons in the order red, blue, green, red. When the last red press is accepted, the machine enters its open state and raises the unlock output for one clock cycle. It then goes back to waiting for a new start press.

Each button press is expected as a single-cycle pulse. An upstream debouncer and edge detector are assumed to produce these pulses. Alongside the three color lines, a summary flag reports that some colored button is down. A color press counts only if the summary flag is high and the expected color is the only color line that is high. A press of the wrong color, or a press of several colors together, sends the machine back to its idle state without unlocking. This means holding every button at once cannot open the door. A synchronous, active-high reset returns the machine to idle.

Top module: `color_code_lock`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine returns to idle. `unlock` then reads 0 after that edge, whatever state the machine was in before, including partway through the code and the open state.
- R2: While idle, the machine stays idle as long as `start_btn` is low, even when colored buttons are pressed. A high `start_btn` at an edge moves it to the "started" step.
- R3: From the started step, sole presses of red, blue, green and red, in that order, take the machine through four steps. The fourth press puts it in the open state, with `unlock` = 1 after that edge.
- R4: In any step between started and the last expected red, an edge with `any_color` low leaves the step unchanged, whatever the color lines carry.
- R5: In those same steps, an edge with `any_color` high and a single color line that is not the expected one returns the machine to idle.
- R6: A press in which the expected color is high together with any other color line returns the machine to idle. This rule also applies to the final red.
- R7: `unlock` is 1 only in the open state. The machine leaves the open state for idle on the next edge whatever the inputs are, so `unlock` stays high for exactly one cycle.
- R8: `start_btn` has no effect once the machine has left idle. A start pulse in any later step does not restart the code and does not reset it.
- R9: An edge with `any_color` high and no color line high, in a step that expects a color, counts as a wrong press and returns the machine to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| start_btn | input | 1 | Start button pulse |
| red_btn | input | 1 | Red button pulse |
| green_btn | input | 1 | Green button pulse |
| blue_btn | input | 1 | Blue button pulse |
| any_color | input | 1 | High while some colored button is pressed |
| unlock | output | 1 | Door release, high for one cycle in the open state |

## Verification
The only output is the one-cycle unlock pulse, so the step the machine holds cannot be seen directly. This matters most after a quiet cycle, an ignored start pulse, or a rejection. To reveal the hidden step, the stimulus follows each such event with the presses that would finish the code from the step the machine should be in. The stimulus also tries the presses that would finish it from the step it must not be in. Whether `unlock` then rises shows which step the machine was holding. Multi-button presses are aimed at both an intermediate step and the final red, where a wrong acceptance would open the door.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

  localparam int NUM_COLORS = 3;
  localparam int COL_RED    = 0;
  localparam int COL_GREEN  = 1;
  localparam int COL_BLUE   = 2;
  localparam int STATE_W    = 3;

  typedef logic [NUM_COLORS-1:0] color_vec_t;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_GOT_R1  = 3'd2,
    ST_GOT_B   = 3'd3,
    ST_GOT_G   = 3'd4,
    ST_OPEN    = 3'd5
  } lock_state_t;

  // One-hot color the given step waits for; zero where no color is expected.
  function automatic color_vec_t wanted_color(lock_state_t st);
    color_vec_t v;
    v = '0;
    case (st)
      ST_ARMED:  v[COL_RED]   = 1'b1;
      ST_GOT_R1: v[COL_BLUE]  = 1'b1;
      ST_GOT_B:  v[COL_GREEN] = 1'b1;
      ST_GOT_G:  v[COL_RED]   = 1'b1;
      default:   v = '0;
    endcase
    return v;
  endfunction

  // Step reached after an accepted press.
  function automatic lock_state_t code_successor(lock_state_t st);
    case (st)
      ST_ARMED:  return ST_GOT_R1;
      ST_GOT_R1: return ST_GOT_B;
      ST_GOT_B:  return ST_GOT_G;
      ST_GOT_G:  return ST_OPEN;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic logic collects_color(lock_state_t st);
    return (st == ST_ARMED) || (st == ST_GOT_R1) ||
           (st == ST_GOT_B) || (st == ST_GOT_G);
  endfunction

  function automatic logic door_released(lock_state_t st);
    return st == ST_OPEN;
  endfunction

endpackage

// File: rtl/ccl_press_judge.sv
module ccl_press_judge
  import ccl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  color_vec_t colors,
  input  logic       any_color,
  input  color_vec_t expect_col,
  output logic       press_quiet,
  output logic       press_good,
  output logic       press_bad
);

  // An exact match against a one-hot target accepts the sole expected color only.
  logic exact_hit;
  assign exact_hit   = (expect_col != '0) && (colors == expect_col);

  assign press_quiet = !any_color;
  assign press_good  = any_color && exact_hit;
  assign press_bad   = any_color && !exact_hit;

  AST_GOOD_IS_SOLE: assert property (@(posedge clk) disable iff (rst)
    press_good |-> (any_color && $countones(colors) == 1)); // R6

  AST_EMPTY_PRESS_BAD: assert property (@(posedge clk) disable iff (rst)
    (any_color && colors == '0) |-> press_bad); // R9

endmodule

// File: rtl/ccl_step.sv
module ccl_step
  import ccl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        press_quiet,
  input  logic        press_good,
  input  logic        press_bad,
  output lock_state_t state_q,
  output color_vec_t  expect_col
);

  lock_state_t state_d;
  logic        ev_advance;
  logic        ev_reject;
  logic        in_code;

  assign in_code    = collects_color(state_q);
  assign expect_col = wanted_color(state_q);
  assign ev_advance = in_code && press_good;
  assign ev_reject  = in_code && press_bad;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ARMED;
      ST_OPEN: state_d = ST_IDLE;
      default: begin
        if (ev_advance)     state_d = code_successor(state_q);
        else if (ev_reject) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  AST_RESET_TO_IDLE: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE)); // R1

  AST_IDLE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_code && press_quiet) |=> $stable(state_q)); // R4

  AST_BAD_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_code && press_bad) |=> (state_q == ST_IDLE)); // R5

  AST_OPEN_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN) |=> (state_q == ST_IDLE)); // R7

endmodule

// File: rtl/ccl_unlock_out.sv
module ccl_unlock_out
  import ccl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_t state_q,
  output logic        unlock
);

  assign unlock = door_released(state_q);

  AST_UNLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock); // R7

endmodule

// File: rtl/color_code_lock.sv
module color_code_lock
  import ccl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_btn,
  input  logic red_btn,
  input  logic green_btn,
  input  logic blue_btn,
  input  logic any_color,
  output logic unlock
);

  color_vec_t  colors;
  color_vec_t  expect_col;
  lock_state_t state_q;
  logic        press_quiet;
  logic        press_good;
  logic        press_bad;

  always_comb begin
    colors            = '0;
    colors[COL_RED]   = red_btn;
    colors[COL_GREEN] = green_btn;
    colors[COL_BLUE]  = blue_btn;
  end

  ccl_press_judge u_judge (
    .clk         (clk),
    .rst         (rst),
    .colors      (colors),
    .any_color   (any_color),
    .expect_col  (expect_col),
    .press_quiet (press_quiet),
    .press_good  (press_good),
    .press_bad   (press_bad)
  );

  ccl_step u_step (
    .clk         (clk),
    .rst         (rst),
    .start       (start_btn),
    .press_quiet (press_quiet),
    .press_good  (press_good),
    .press_bad   (press_bad),
    .state_q     (state_q),
    .expect_col  (expect_col)
  );

  ccl_unlock_out u_out (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .unlock  (unlock)
  );

endmodule

// File: tb/test_color_code_lock.sv
`timescale 1ns/1ps
module test_color_code_lock;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_btn = 1'b0;
  logic red_btn = 1'b0;
  logic green_btn = 1'b0;
  logic blue_btn = 1'b0;
  logic any_color = 1'b0;
  logic unlock;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  color_code_lock i_color_code_lock (
    .clk(clk), .rst(rst), .start_btn(start_btn), .red_btn(red_btn),
    .green_btn(green_btn), .blue_btn(blue_btn), .any_color(any_color),
    .unlock(unlock)
  );

  // Vector layout: {req[3:0], s, r, g, b, a, expected unlock after the edge}
  localparam int NV = 63;
  localparam logic [9:0] VEC [NV] = '{
    {4'd3, 6'b100000}, {4'd3, 6'b010010}, {4'd3, 6'b000110}, {4'd3, 6'b001010},
    {4'd3, 6'b010011},                                       // R3 full code opens
    {4'd7, 6'b000000},                                       // R7 back to idle
    {4'd2, 6'b010010}, {4'd2, 6'b000110}, {4'd2, 6'b001010}, {4'd2, 6'b010010}, // R2
    {4'd4, 6'b100000}, {4'd4, 6'b000000}, {4'd4, 6'b010010}, {4'd4, 6'b010000},
    {4'd4, 6'b000110}, {4'd4, 6'b000000}, {4'd4, 6'b001010}, {4'd4, 6'b001000},
    {4'd4, 6'b010011},                                       // R4 holds survive
    {4'd7, 6'b010010}, {4'd7, 6'b000110}, {4'd7, 6'b001010}, {4'd7, 6'b010010}, // R7
    {4'd5, 6'b100000}, {4'd5, 6'b010010}, {4'd5, 6'b001010}, {4'd5, 6'b001010},
    {4'd5, 6'b010010}, {4'd5, 6'b100000}, {4'd5, 6'b000110}, {4'd5, 6'b010010},
    {4'd5, 6'b000110}, {4'd5, 6'b001010}, {4'd5, 6'b010010}, // R5 wrong colors
    {4'd6, 6'b100000}, {4'd6, 6'b010110}, {4'd6, 6'b000110}, {4'd6, 6'b001010},
    {4'd6, 6'b010010}, {4'd6, 6'b100000}, {4'd6, 6'b010010}, {4'd6, 6'b000110},
    {4'd6, 6'b001010}, {4'd6, 6'b011110},                    // R6 multi press
    {4'd8, 6'b100000}, {4'd8, 6'b010010}, {4'd8, 6'b100000}, {4'd8, 6'b000110},
    {4'd8, 6'b001010}, {4'd8, 6'b010011}, {4'd7, 6'b000000}, // R8 start ignored
    {4'd9, 6'b100000}, {4'd9, 6'b000010}, {4'd9, 6'b010010}, {4'd9, 6'b000110},
    {4'd9, 6'b001010}, {4'd9, 6'b010010},                    // R9 empty press
    {4'd8, 6'b100000}, {4'd8, 6'b100000}, {4'd8, 6'b010010}, {4'd8, 6'b000110},
    {4'd8, 6'b001010}, {4'd8, 6'b010011}
  };

  task automatic drive(input logic s, input logic r, input logic g,
                       input logic b, input logic a);
    start_btn = s; red_btn = r; green_btn = g; blue_btn = b; any_color = a;
  endtask

  task automatic edge_check(input logic exp, input int req, input string what);
    @(negedge clk);
    checks++;
    if (unlock !== exp) begin
      errors++;
      $display("FAIL R%0d %s: unlock=%b expected=%b", req, what, unlock, exp);
    end
  endtask

  task automatic enter_code_to_green();
    drive(1,0,0,0,0); edge_check(1'b0, 3, "start");
    drive(0,1,0,0,1); edge_check(1'b0, 3, "red");
    drive(0,0,0,1,1); edge_check(1'b0, 3, "blue");
    drive(0,0,1,0,1); edge_check(1'b0, 3, "green");
  endtask

  initial begin
    drive(0,0,0,0,0);
    rst = 1'b1;
    edge_check(1'b0, 1, "reset state");       // R1
    edge_check(1'b0, 1, "reset held");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      edge_check(VEC[i][0], int'(VEC[i][9:6]), $sformatf("vector %0d", i));
    end

    // R1: reset partway through the code, with the final red present
    drive(0,0,0,0,0); edge_check(1'b0, 1, "settle");
    enter_code_to_green();
    drive(0,1,0,0,1); rst = 1'b1;
    edge_check(1'b0, 1, "reset beats final red");
    rst = 1'b0;
    edge_check(1'b0, 1, "idle after reset");
    drive(0,0,0,1,1); edge_check(1'b0, 1, "no resume blue");
    drive(0,0,1,0,1); edge_check(1'b0, 1, "no resume green");
    drive(0,1,0,0,1); edge_check(1'b0, 1, "no resume red");

    // R1: reset while open
    enter_code_to_green();
    drive(0,1,0,0,1); edge_check(1'b1, 3, "opened");
    drive(0,0,0,0,0); rst = 1'b1;
    edge_check(1'b0, 1, "reset in open state");
    rst = 1'b0;
    edge_check(1'b0, 1, "idle after open reset");

    // R6: final red pressed with blue
    enter_code_to_green();
    drive(0,1,0,1,1); edge_check(1'b0, 6, "red+blue at last step");
    drive(0,1,0,0,1); edge_check(1'b0, 6, "no retry without start");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule